// File: doc/BRIEF.md
# Pulse Train Transmitter with Carrier

This block turns a short list of timed level segments into a waveform on a single output pin. Software first fills a small entry memory through a write port. Each 32-bit word holds two segments. Each segment gives an output level and a duration in ticks. A start pulse plays the segments in order. A tick is a programmable number of clock cycles. Playback ends, or starts again from the first word, when it meets a segment of zero duration or runs past the last word.

In one-shot mode the block drops to idle at the end and pulses a done interrupt. In continuous mode it starts again from the first word. It can count these restarts and raise a loop interrupt when the count reaches a programmed number, and it can stop at that point. A threshold interrupt fires each time a programmed number of words has been sent. When the block is not playing, the pin shows a programmable idle level if the idle drive is enabled.

An optional carrier can chop the segments that have a chosen level. The carrier has its own high and low times. It can act only while data is being sent, or at all times.

Top module: `pulse_tx`

## Requirements
- R1: After reset the pin, its output enable and all three interrupts are low while idle drive is off.
- R2: Each word is split into two segments. Bits [15:0] hold the first segment and bits [31:16] the second. In each segment the top bit is the level and the lower 15 bits are the duration. Starting with word 0 and going up in address, the first segment of a word plays before its second. The first cycle after the start edge shows the first segment. Each segment holds its level for duration × divider clock cycles.
- R3: A segment of duration 0 is an end marker. In one-shot mode, reaching the marker returns the block to idle in the next cycle and raises done_o for exactly one cycle. If the marker is the very first segment, done_o pulses in the first cycle after start and nothing is sent.
- R4: The tick divider produces one tick every div_i cycles, and div_i of 0 or 1 gives one tick per cycle. A start restarts the divider.
- R5: When there is no marker, the second segment of the last word ends the pass. One-shot mode then ends with done_o.
- R6: In continuous mode, the end of a pass (a marker or the end of memory) plays word 0 again in the next cycle. This repeats without limit while loop counting is off, and done_o never pulses.
- R7: With loop counting on, each restart adds one to a loop counter. When the counter reaches loop_num_i, loop_o pulses for one cycle and the counter clears. A loop_num_i of 0 never fires.
- R8: If loop-stop is also on, the block goes idle at the restart where loop_o fires, without a done_o pulse.
- R9: A loop_clr_i pulse clears the loop counter. The counter is kept across starts otherwise.
- R10: Words whose second segment has finished are counted from start. When the count reaches ent_lim_i, thr_o pulses for one cycle and the count restarts. An ent_lim_i of 0 never fires.
- R11: stop_i makes the block idle in the next cycle with no interrupt. start_i takes precedence over stop_i and restarts from word 0 even while sending.
- R12: pin_oe_o is high while sending or while idle_en_i is set. While idle, the pin shows idle_lvl_i when idle drive is on and 0 otherwise.
- R13: The carrier is high for car_hi_i cycles and then low for car_lo_i cycles, with its phase restarting at start. When car_en_i is set, it replaces the data on every cycle whose data level equals car_pol_i. With car_gate_i = 1 this happens only while sending; with car_gate_i = 0 it also happens in idle. With car_en_i = 0 the carrier has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Entry memory write strobe |
| wr_addr_i | input | 3 | Entry memory word address |
| wr_data_i | input | 32 | Entry word, two segments |
| start_i | input | 1 | Begin playback from word 0 |
| stop_i | input | 1 | Abort playback |
| loop_clr_i | input | 1 | Clear the loop counter |
| div_i | input | 8 | Clock cycles per duration tick |
| cont_i | input | 1 | Continuous mode |
| loop_en_i | input | 1 | Count restarts |
| loop_stop_i | input | 1 | Halt when the loop count is reached |
| loop_num_i | input | 10 | Loop count target |
| ent_lim_i | input | 9 | Word count for the threshold event |
| idle_lvl_i | input | 1 | Idle pin level |
| idle_en_i | input | 1 | Drive the pin while idle |
| car_en_i | input | 1 | Carrier enable |
| car_gate_i | input | 1 | 1: carrier only while sending |
| car_pol_i | input | 1 | Data level that carries the carrier |
| car_hi_i | input | 16 | Carrier high time in cycles |
| car_lo_i | input | 16 | Carrier low time in cycles |
| pin_o | output | 1 | Waveform output |
| pin_oe_o | output | 1 | Output enable for the pin |
| done_o | output | 1 | One-shot completion pulse |
| thr_o | output | 1 | Word threshold pulse |
| loop_o | output | 1 | Loop count reached pulse |

## Verification
The cycles are counted from the clock edge that samples start_i. Cycle n shows whatever segment covers ticks up to n. A segment that ends at cycle T is followed in cycle T+1 by the next segment, the restart, or idle. The done_o, thr_o and loop_o pulses also appear in cycle T+1, because each passes through one register. The bench builds a table of expected pin, enable and interrupt values for every cycle after start. It works this table out from the segment list, the divider, the loop and threshold settings, and the carrier period. It then compares all five outputs on the falling edge of every cycle. A stop_i applied after sample n takes effect from sample n+1, and the table drops all activity from that point on.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  localparam int DUR_W   = 15;
  localparam int HALF_W  = DUR_W + 1;
  localparam int ENTRY_W = 2 * HALF_W;

  typedef struct packed {
    logic             lvl;
    logic [DUR_W-1:0] dur;
  } ptx_half_t;
endpackage

// File: rtl/ptx_mem.sv
module ptx_mem #(
  parameter int DEPTH = 8,
  parameter int NRD   = 3,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic [W-1:0]           wr_data_i,
  input  logic [NRD-1:0][AW-1:0] rd_addr_i,
  output logic [NRD-1:0][W-1:0]  rd_data_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data_o[g] = mem_q[rd_addr_i[g]];
  end
endmodule

// File: rtl/ptx_tick_div.sv
module ptx_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = (div_i <= DIV_W'(1)) || (cnt_q >= div_i - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/ptx_carrier.sv
module ptx_carrier #(
  parameter int CAR_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CAR_W-1:0] hi_i,
  input  logic [CAR_W-1:0] lo_i,
  output logic             wave_o
);
  logic             ph_q;
  logic [CAR_W-1:0] cnt_q;
  logic [CAR_W-1:0] span;
  logic             flip;

  assign span   = ph_q ? hi_i : lo_i;
  assign flip   = (span <= CAR_W'(1)) || (cnt_q >= span - CAR_W'(1));
  assign wave_o = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= 1'b1;
      cnt_q <= '0;
    end else if (restart_i) begin
      ph_q  <= 1'b1;
      cnt_q <= '0;
    end else if (flip) begin
      ph_q  <= ~ph_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CAR_W'(1);
    end
  end
endmodule

// File: rtl/ptx_player.sv
module ptx_player
  import ptx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int LOOP_W = 10,
  parameter int LIM_W  = 9,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic                      start_i,
  input  logic                      stop_i,
  input  logic                      loop_clr_i,
  input  logic                      cont_i,
  input  logic                      loop_en_i,
  input  logic                      loop_stop_i,
  input  logic [LOOP_W-1:0]         loop_num_i,
  input  logic [LIM_W-1:0]          ent_lim_i,
  output logic [2:0][AW-1:0]        rd_addr_o,
  input  logic [2:0][ENTRY_W-1:0]   rd_data_i,
  output logic                      busy_o,
  output logic                      lvl_o,
  output logic                      done_o,
  output logic                      thr_o,
  output logic                      loop_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic              busy_q, hsel_q, done_q, thr_q, loop_q;
  logic [AW-1:0]     idx_q;
  logic [DUR_W-1:0]  dcnt_q;
  logic [LIM_W-1:0]  ecnt_q;
  logic [LOOP_W-1:0] lcnt_q;

  ptx_half_t cur_h, nxt_h, first_h;
  logic      expire, at_end, nxt_mark, wrap, ent_done, thr_hit;
  logic      loop_inc, loop_hit, halt;

  assign rd_addr_o[0] = idx_q;
  assign rd_addr_o[1] = (idx_q == LAST) ? '0 : idx_q + AW'(1);
  assign rd_addr_o[2] = '0;

  assign cur_h   = hsel_q ? ptx_half_t'(rd_data_i[0][ENTRY_W-1:HALF_W])
                          : ptx_half_t'(rd_data_i[0][HALF_W-1:0]);
  assign nxt_h   = hsel_q ? ptx_half_t'(rd_data_i[1][HALF_W-1:0])
                          : ptx_half_t'(rd_data_i[0][ENTRY_W-1:HALF_W]);
  assign first_h = ptx_half_t'(rd_data_i[2][HALF_W-1:0]);

  assign expire   = busy_q && tick_i &&
                    ((cur_h.dur <= DUR_W'(1)) || (dcnt_q >= cur_h.dur - DUR_W'(1)));
  assign at_end   = hsel_q && (idx_q == LAST);
  assign nxt_mark = !at_end && (nxt_h.dur == '0);
  assign wrap     = expire && (at_end || nxt_mark);
  assign ent_done = expire && hsel_q;
  assign thr_hit  = ({1'b0, ecnt_q} + (LIM_W+1)'(1)) == {1'b0, ent_lim_i};
  assign loop_inc = wrap && cont_i && loop_en_i;
  assign loop_hit = ({1'b0, lcnt_q} + (LOOP_W+1)'(1)) == {1'b0, loop_num_i};
  assign halt     = wrap && (!cont_i || (loop_inc && loop_hit && loop_stop_i));

  assign busy_o = busy_q;
  assign lvl_o  = cur_h.lvl;
  assign done_o = done_q;
  assign thr_o  = thr_q;
  assign loop_o = loop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      hsel_q <= 1'b0;
      idx_q  <= '0;
      dcnt_q <= '0;
      ecnt_q <= '0;
      done_q <= 1'b0;
      thr_q  <= 1'b0;
      loop_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      thr_q  <= 1'b0;
      loop_q <= 1'b0;
      if (start_i) begin
        busy_q <= (first_h.dur != '0);
        done_q <= (first_h.dur == '0);
        idx_q  <= '0;
        hsel_q <= 1'b0;
        dcnt_q <= '0;
        ecnt_q <= '0;
      end else if (stop_i) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        if (tick_i) dcnt_q <= expire ? '0 : dcnt_q + DUR_W'(1);
        if (ent_done) begin
          if (thr_hit) begin
            ecnt_q <= '0;
            thr_q  <= 1'b1;
          end else begin
            ecnt_q <= ecnt_q + LIM_W'(1);
          end
        end
        if (wrap) begin
          idx_q  <= '0;
          hsel_q <= 1'b0;
          if (loop_inc && loop_hit) loop_q <= 1'b1;
          if (halt) begin
            busy_q <= 1'b0;
            done_q <= !cont_i;
          end
        end else if (expire) begin
          hsel_q <= ~hsel_q;
          if (hsel_q) idx_q <= idx_q + AW'(1);
        end
      end
    end
  end

  // loop counter survives start; only clear or target reach resets it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  lcnt_q <= '0;
    else if (loop_clr_i)                          lcnt_q <= '0;
    else if (!start_i && !stop_i && loop_inc)     lcnt_q <= loop_hit ? '0 : lcnt_q + LOOP_W'(1);
  end
endmodule

// File: rtl/pulse_tx.sv
module pulse_tx
  import ptx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 8,
  parameter int LOOP_W = 10,
  parameter int LIM_W  = 9,
  parameter int CAR_W  = 16,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [AW-1:0]      wr_addr_i,
  input  logic [ENTRY_W-1:0] wr_data_i,
  input  logic               start_i,
  input  logic               stop_i,
  input  logic               loop_clr_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               cont_i,
  input  logic               loop_en_i,
  input  logic               loop_stop_i,
  input  logic [LOOP_W-1:0]  loop_num_i,
  input  logic [LIM_W-1:0]   ent_lim_i,
  input  logic               idle_lvl_i,
  input  logic               idle_en_i,
  input  logic               car_en_i,
  input  logic               car_gate_i,
  input  logic               car_pol_i,
  input  logic [CAR_W-1:0]   car_hi_i,
  input  logic [CAR_W-1:0]   car_lo_i,
  output logic               pin_o,
  output logic               pin_oe_o,
  output logic               done_o,
  output logic               thr_o,
  output logic               loop_o
);
  logic [2:0][AW-1:0]      rd_addr;
  logic [2:0][ENTRY_W-1:0] rd_data;
  logic tick, wave, busy, lvl, data_lvl, car_on;

  ptx_mem #(.DEPTH(DEPTH), .NRD(3), .W(ENTRY_W)) u_mem (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .rd_addr_i(rd_addr), .rd_data_o(rd_data)
  );

  ptx_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .clr_i(start_i), .div_i, .tick_o(tick)
  );

  ptx_carrier #(.CAR_W(CAR_W)) u_car (
    .clk_i, .rst_ni, .restart_i(start_i), .hi_i(car_hi_i), .lo_i(car_lo_i), .wave_o(wave)
  );

  ptx_player #(.DEPTH(DEPTH), .LOOP_W(LOOP_W), .LIM_W(LIM_W)) u_play (
    .clk_i, .rst_ni, .tick_i(tick), .start_i, .stop_i, .loop_clr_i,
    .cont_i, .loop_en_i, .loop_stop_i, .loop_num_i, .ent_lim_i,
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .busy_o(busy), .lvl_o(lvl), .done_o, .thr_o, .loop_o
  );

  assign data_lvl = busy ? lvl : idle_lvl_i;
  assign pin_oe_o = busy | idle_en_i;
  assign car_on   = car_en_i & (busy | ~car_gate_i) & (data_lvl == car_pol_i);
  assign pin_o    = pin_oe_o & (car_on ? wave : data_lvl);
endmodule

// File: rtl/ptx_chk.sv
module ptx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic stop_i,
  input logic loop_stop_i,
  input logic car_gate_i,
  input logic idle_lvl_i,
  input logic busy_i,
  input logic pin_o,
  input logic pin_oe_o,
  input logic done_o,
  input logic thr_o,
  input logic loop_o
);
  p_done_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_i);

  p_loop_halt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loop_o && $past(loop_stop_i)) |-> !busy_i);

  p_thr_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thr_o |=> !thr_o);

  p_stop_halts_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !start_i) |=> (!busy_i && !done_o && !thr_o && !loop_o));

  p_undriven_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_oe_o |-> !pin_o);

  p_gate_idle_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && car_gate_i && pin_oe_o) |-> (pin_o == idle_lvl_i));
endmodule

bind pulse_tx ptx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .loop_stop_i(loop_stop_i), .car_gate_i(car_gate_i), .idle_lvl_i(idle_lvl_i),
  .busy_i(busy), .pin_o(pin_o), .pin_oe_o(pin_oe_o),
  .done_o(done_o), .thr_o(thr_o), .loop_o(loop_o)
);

// File: tb/sim_pulse_tx.sv
`timescale 1ns/1ps
module sim_pulse_tx;
  localparam int DEPTH = 8;
  localparam int MAXN  = 700;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 0, start_i = 0, stop_i = 0, loop_clr_i = 0;
  logic [2:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [7:0] div_i = 8'd1;
  logic cont_i = 0, loop_en_i = 0, loop_stop_i = 0;
  logic [9:0] loop_num_i = '0;
  logic [8:0] ent_lim_i = '0;
  logic idle_lvl_i = 0, idle_en_i = 0, car_en_i = 0, car_gate_i = 1, car_pol_i = 1;
  logic [15:0] car_hi_i = 16'd1, car_lo_i = 16'd1;
  logic pin_o, pin_oe_o, done_o, thr_o, loop_o;

  always #5 clk_i = ~clk_i;

  pulse_tx u0 (.*);

  int n_cmp = 0, n_bad = 0;
  bit fin = 0;
  logic [31:0] bmem [DEPTH];
  bit esend [MAXN], elvl [MAXN], edone [MAXN], ethr [MAXN], eloop [MAXN];
  int plvl [2*DEPTH], pdur [2*DEPTH], ph1 [2*DEPTH];
  int pcnt;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk(int l0, int d0, int l1, int d1);
    return {l1[0], d1[14:0], l0[0], d0[14:0]};
  endfunction

  task automatic load();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk_i);
      wr_en_i = 1; wr_addr_i = i[2:0]; wr_data_i = bmem[i];
    end
    @(negedge clk_i);
    wr_en_i = 0;
  endtask

  // expected per-cycle table, cycle 1 = first cycle after the start edge
  task automatic build(int stop_at, int init_loops);
    int t, ec, lc, span;
    bit run;
    for (int n = 0; n < MAXN; n++) begin
      esend[n] = 0; elvl[n] = 0; edone[n] = 0; ethr[n] = 0; eloop[n] = 0;
    end
    pcnt = 0;
    for (int p = 0; p < 2*DEPTH; p++) begin
      int d;
      d = (p[0] ? int'(bmem[p/2][30:16]) : int'(bmem[p/2][14:0]));
      if (d == 0) break;
      plvl[pcnt] = p[0] ? int'(bmem[p/2][31]) : int'(bmem[p/2][15]);
      pdur[pcnt] = d; ph1[pcnt] = p[0]; pcnt++;
    end
    t = 0; ec = 0; lc = init_loops; run = 1;
    if (pcnt == 0) begin edone[1] = 1; run = 0; end
    while (run && t < MAXN) begin
      for (int h = 0; h < pcnt; h++) begin
        span = pdur[h] * ((div_i <= 1) ? 1 : int'(div_i));
        for (int k = 1; k <= span; k++)
          if (t + k < MAXN) begin esend[t+k] = 1; elvl[t+k] = plvl[h][0]; end
        t += span;
        if (ph1[h] != 0) begin
          ec++;
          if (ec == int'(ent_lim_i)) begin ec = 0; if (t+1 < MAXN) ethr[t+1] = 1; end
        end
      end
      if (!cont_i) begin
        if (t+1 < MAXN) edone[t+1] = 1;
        run = 0;
      end else if (loop_en_i) begin
        lc++;
        if (lc == int'(loop_num_i)) begin
          lc = 0;
          if (t+1 < MAXN) eloop[t+1] = 1;
          if (loop_stop_i) run = 0;
        end
      end
    end
    if (stop_at > 0)
      for (int n = stop_at + 1; n < MAXN; n++) begin
        esend[n] = 0; edone[n] = 0; ethr[n] = 0; eloop[n] = 0;
      end
  endtask

  task automatic run(string tag, int ncyc, int stop_at, int init_loops, bit lrst, bit keep);
    bit l, oe, con, wv, ep;
    int per;
    if (lrst) begin
      @(negedge clk_i); loop_clr_i = 1;
      @(negedge clk_i); loop_clr_i = 0;
      init_loops = 0;
    end
    build(stop_at, init_loops);
    per = int'(car_hi_i) + int'(car_lo_i);
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
    for (int n = 1; n <= ncyc; n++) begin
      l   = esend[n] ? elvl[n] : idle_lvl_i;
      oe  = esend[n] | idle_en_i;
      wv  = ((n - 1) % per) < int'(car_hi_i);
      con = car_en_i && (esend[n] || !car_gate_i) && (l == car_pol_i);
      ep  = oe && (con ? wv : l);
      chk(tag, "pin", pin_o, ep);
      chk(tag, "oe", pin_oe_o, oe);
      chk(tag, "done", done_o, edone[n]);
      chk(tag, "thr", thr_o, ethr[n]);
      chk(tag, "loop", loop_o, eloop[n]);
      if (n == stop_at) stop_i = 1;
      @(negedge clk_i);
      stop_i = 0;
    end
    if (!keep) begin
      stop_i = 1; @(negedge clk_i); stop_i = 0;
    end
  endtask

  task automatic cfg(int dv, bit ct, bit le, bit ls, int ln, int lim);
    div_i = dv[7:0]; cont_i = ct; loop_en_i = le; loop_stop_i = ls;
    loop_num_i = ln[9:0]; ent_lim_i = lim[8:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!fin) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'h5eed_0042);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", "pin", pin_o, 0);
    chk("R1", "oe", pin_oe_o, 0);
    chk("R1", "irq", {done_o, thr_o, loop_o}, 0);

    // R2 R3 marker in second word
    for (int i = 0; i < DEPTH; i++) bmem[i] = mk(1, 1, 0, 1);
    bmem[0] = mk(1, 3, 0, 2); bmem[1] = mk(1, 1, 0, 0);
    load();
    cfg(1, 0, 0, 0, 0, 0);
    run("R3", 12, 0, 0, 1, 0);
    // R4 divider 3 and divider 0
    cfg(3, 0, 0, 0, 0, 0);
    run("R4", 24, 0, 0, 1, 0);
    cfg(0, 0, 0, 0, 0, 0);
    run("R4", 10, 0, 0, 1, 0);
    // R3 marker as very first segment
    bmem[0] = mk(1, 0, 0, 4);
    load();
    run("R3", 6, 0, 0, 1, 0);

    // R5 no marker, whole memory, R10 threshold every 3 words
    for (int i = 0; i < DEPTH; i++) bmem[i] = mk(i % 2, 1, 1, 2);
    load();
    cfg(1, 0, 0, 0, 0, 3);
    run("R5", 30, 0, 0, 1, 0);
    cfg(2, 0, 0, 0, 0, 0);
    run("R10", 55, 0, 0, 1, 0);
    // R5 continuous wrap at end of memory, R10 threshold across passes
    cfg(1, 1, 0, 0, 0, 5);
    run("R5", 80, 0, 0, 1, 0);

    // R6 continuous with marker, no loop counting
    bmem[0] = mk(1, 2, 0, 1); bmem[1] = mk(1, 3, 0, 2); bmem[2] = mk(1, 0, 0, 0);
    load();
    cfg(1, 1, 0, 0, 0, 0);
    run("R6", 60, 0, 0, 1, 0);
    // R7 loop counting, target 2, no stop
    cfg(1, 1, 1, 0, 2, 0);
    run("R7", 70, 0, 0, 1, 0);
    // R7 target 0 never fires
    cfg(1, 1, 1, 0, 0, 0);
    run("R7", 50, 0, 0, 1, 0);
    // R8 loop stop after 3 passes
    cfg(1, 1, 1, 1, 3, 0);
    run("R8", 40, 0, 0, 1, 0);

    // R9 counter kept across starts, then cleared (pass length 8 cycles)
    cfg(1, 1, 1, 1, 2, 0);
    run("R9", 10, 10, 0, 1, 0);
    run("R9", 20, 0, 1, 0, 0);
    run("R9", 10, 10, 0, 1, 0);
    run("R9", 24, 0, 0, 1, 0);

    // R11 stop mid one-shot, then start while sending
    cfg(2, 0, 0, 0, 0, 1);
    run("R11", 20, 5, 0, 1, 0);
    cfg(1, 1, 0, 0, 0, 0);
    run("R11", 5, 0, 0, 1, 1);
    run("R11", 20, 0, 0, 1, 0);

    // R12 idle drive variants
    cfg(1, 0, 0, 0, 0, 0);
    idle_en_i = 0; idle_lvl_i = 1;
    run("R12", 16, 0, 0, 1, 0);
    idle_en_i = 1; idle_lvl_i = 1;
    run("R12", 16, 0, 0, 1, 0);
    idle_en_i = 1; idle_lvl_i = 0;
    run("R12", 16, 0, 0, 1, 0);

    // R13 carrier on high level gated, on low level, ungated in idle, disabled
    car_hi_i = 16'd2; car_lo_i = 16'd1;
    car_en_i = 1; car_gate_i = 1; car_pol_i = 1; idle_lvl_i = 1;
    run("R13", 20, 0, 0, 1, 0);
    car_pol_i = 0; idle_lvl_i = 0;
    run("R13", 20, 0, 0, 1, 0);
    car_gate_i = 0; car_hi_i = 16'd1; car_lo_i = 16'd3;
    run("R13", 24, 0, 0, 1, 0);
    car_en_i = 0;
    run("R13", 16, 0, 0, 1, 0);

    // R2 random mixes
    for (int r = 0; r < 30; r++) begin
      int mp;
      for (int i = 0; i < DEPTH; i++)
        bmem[i] = mk($urandom % 2, 1 + $urandom % 5, $urandom % 2, 1 + $urandom % 5);
      mp = $urandom % 20;
      if (mp < 2*DEPTH) begin
        if (mp % 2 == 1) bmem[mp/2][30:16] = '0;
        else             bmem[mp/2][14:0]  = '0;
      end
      load();
      cfg(1 + $urandom % 3, $urandom % 2, $urandom % 2, $urandom % 2,
          1 + $urandom % 3, 1 + $urandom % 4);
      idle_en_i = $urandom % 2; idle_lvl_i = $urandom % 2;
      car_en_i = $urandom % 2; car_gate_i = $urandom % 2; car_pol_i = $urandom % 2;
      car_hi_i = 16'(1 + $urandom % 4); car_lo_i = 16'(1 + $urandom % 4);
      run("R2", 150, ($urandom % 2) ? 0 : 5 + $urandom % 90, 0, 1, 0);
    end

    fin = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule